// File: doc/BRIEF.md
# DRAM-Strobe to SRAM Bridge

This block lets a static RAM occupy the place of a 16-bit dynamic RAM bank on a host bus. That bus carries a multiplexed 9-bit address, an active-low row strobe, two active-low column strobes (one per byte lane) and an active-low write enable. The bridge oversamples all of these with a fast system clock. It latches the row half on the row strobe's falling edge and the column half on the first falling column strobe. It then presents an 18-bit combined address, per-lane byte enables, a chip enable and a write strobe to an SRAM port.

The 16-bit data path is split into separate in, out and output-enable signals on each side, so a pad ring or a test harness can build the bidirectional buses. On a read the SRAM data is passed to the host bus with its driver enabled. On a write the host data is passed toward the SRAM and the host driver stays off.

The system clock must run several times faster than the strobe timing. Every strobe and address edge costs a fixed three-clock latency: two synchronizer flops and one output register. The port has no flow control. Strobes are accepted as they arrive, and the SRAM is assumed to complete within one access window.

Top module: `dram_sram_bridge`

## Requirements
- R1: While reset is asserted and right after it, sram_ce_n, sram_we_n, sram_ub_n and sram_lb_n are 1, both output enables are 0 and sram_addr is 0.
- R2: The multiplexed address present when row_strb_n falls is stored and appears on sram_addr[17:9].
- R3: The multiplexed address present when the first of colu_strb_n or coll_strb_n falls is stored and appears on sram_addr[8:0]. This happens whether or not the row strobe is low, and in the same clock that chip enable asserts.
- R4: A column strobe falling while row_strb_n is low drives sram_ce_n to 0 on the third rising clock edge after the strobe change, and not earlier.
- R5: sram_ub_n follows colu_strb_n and sram_lb_n follows coll_strb_n during an access. A word access enables both lanes; a byte access enables only its own lane.
- R6: A column strobe falling while row_strb_n is high (refresh order) never asserts sram_ce_n, even when row_strb_n falls later while the column strobe is still low.
- R7: During a read access (wr_en_n high), host_data_oe is 1, host_data_out equals sram_data_in, and sram_data_oe is 0.
- R8: During a write access (wr_en_n low), sram_we_n is 0, sram_data_oe is 1, sram_data_out equals host_data_in, and host_data_oe is 0.
- R9: Once both column strobes are high, or row_strb_n is high, chip enable, byte enables, write strobe and both output enables return to inactive after the same three-edge latency.
- R10: With row_strb_n held low, a new column strobe fall after the previous one ended starts a new access. It uses the new column and keeps the stored row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mux_addr | input | 9 | Multiplexed row/column address from the host |
| row_strb_n | input | 1 | Active-low row strobe |
| colu_strb_n | input | 1 | Active-low column strobe, upper byte |
| coll_strb_n | input | 1 | Active-low column strobe, lower byte |
| wr_en_n | input | 1 | Active-low host write enable |
| host_data_in | input | 16 | Data from the host bus (write data) |
| host_data_out | output | 16 | Data toward the host bus (read data) |
| host_data_oe | output | 1 | Host bus driver enable |
| sram_addr | output | 18 | Row in [17:9], column in [8:0] |
| sram_ce_n | output | 1 | Active-low SRAM chip enable |
| sram_we_n | output | 1 | Active-low SRAM write strobe |
| sram_ub_n | output | 1 | Active-low upper byte enable |
| sram_lb_n | output | 1 | Active-low lower byte enable |
| sram_data_in | input | 16 | Data from the SRAM (read data) |
| sram_data_out | output | 16 | Data toward the SRAM (write data) |
| sram_data_oe | output | 1 | SRAM-side data driver enable |

## Verification
The bench drops a column strobe while the row strobe is still high and then lowers the row. A bridge that gated chip enable on the current strobe levels instead of on a column edge would start a spurious access during refresh. It runs page-mode accesses with the row held low. A design that recaptured the row, or that did not rearm after both columns rose, would show a wrong upper address or a missing enable. Single-lane reads and writes catch swapped or merged byte enables, and a write with both drivers checked catches bus contention. An exact-cycle probe of chip enable catches a bridge that skipped or doubled the synchronizer stage.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  localparam int ADDR_W_DEF = 9;
  localparam int DATA_W_DEF = 16;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACCESS = 1'b1
  } dsb_state_e;
endpackage

// File: rtl/dsb_sync.sv
module dsb_sync #(
  parameter int             WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/dsb_capture.sv
module dsb_capture #(
  parameter int ADDR_W = dsb_pkg::ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic              row_act,
  input  logic              col_any_act,
  output logic              col_fall,
  output logic [ADDR_W-1:0] row_q,
  output logic [ADDR_W-1:0] col_q
);
  logic row_act_d;
  logic col_act_d;
  logic row_fall;

  assign row_fall = row_act & ~row_act_d;
  assign col_fall = col_any_act & ~col_act_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_act_d <= 1'b0;
      col_act_d <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
    end else begin
      row_act_d <= row_act;
      col_act_d <= col_any_act;
      if (row_fall) row_q <= addr_s;
      if (col_fall) col_q <= addr_s;
    end
  end
endmodule

// File: rtl/dsb_sequencer.sv
module dsb_sequencer (
  input  logic clk,
  input  logic rst_n,
  input  logic row_act,
  input  logic colu_act,
  input  logic coll_act,
  input  logic wr_act,
  input  logic col_fall,
  output logic ce_q,
  output logic ub_q,
  output logic lb_q,
  output logic wr_q
);
  import dsb_pkg::*;

  dsb_state_e state_q;
  dsb_state_e state_d;
  logic       col_any;
  logic       start_acc;
  logic       end_acc;

  assign col_any   = colu_act | coll_act;
  assign start_acc = (state_q == ST_IDLE) && col_fall && row_act;
  assign end_acc   = (state_q == ST_ACCESS) && (!row_act || !col_any);

  always_comb begin
    state_d = state_q;
    if (start_acc)    state_d = ST_ACCESS;
    else if (end_acc) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_q    <= 1'b0;
      ub_q    <= 1'b0;
      lb_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d == ST_ACCESS) begin
        ce_q <= 1'b1;
        ub_q <= colu_act;
        lb_q <= coll_act;
        wr_q <= wr_act;
      end else begin
        ce_q <= 1'b0;
        ub_q <= 1'b0;
        lb_q <= 1'b0;
        wr_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dram_sram_bridge.sv
module dram_sram_bridge #(
  parameter int ADDR_W = dsb_pkg::ADDR_W_DEF,
  parameter int DATA_W = dsb_pkg::DATA_W_DEF,
  localparam int SRAM_AW = 2 * ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  mux_addr,
  input  logic               row_strb_n,
  input  logic               colu_strb_n,
  input  logic               coll_strb_n,
  input  logic               wr_en_n,
  input  logic [DATA_W-1:0]  host_data_in,
  output logic [DATA_W-1:0]  host_data_out,
  output logic               host_data_oe,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic               sram_ce_n,
  output logic               sram_we_n,
  output logic               sram_ub_n,
  output logic               sram_lb_n,
  input  logic [DATA_W-1:0]  sram_data_in,
  output logic [DATA_W-1:0]  sram_data_out,
  output logic               sram_data_oe
);
  localparam int STRB_W = 4;

  logic [STRB_W-1:0] strb_raw;
  logic [STRB_W-1:0] strb_s;
  logic [ADDR_W-1:0] addr_s;
  logic              row_act, colu_act, coll_act, wr_act;
  logic              col_fall;
  logic [ADDR_W-1:0] row_q, col_q;
  logic              ce_q, ub_q, lb_q, wr_q;

  assign strb_raw = {wr_en_n, coll_strb_n, colu_strb_n, row_strb_n};

  dsb_sync #(.WIDTH(STRB_W), .RST_VAL({STRB_W{1'b1}})) u_strb_sync (
    .clk(clk), .rst_n(rst_n), .d(strb_raw), .q(strb_s)
  );

  dsb_sync #(.WIDTH(ADDR_W), .RST_VAL({ADDR_W{1'b0}})) u_addr_sync (
    .clk(clk), .rst_n(rst_n), .d(mux_addr), .q(addr_s)
  );

  assign row_act  = ~strb_s[0];
  assign colu_act = ~strb_s[1];
  assign coll_act = ~strb_s[2];
  assign wr_act   = ~strb_s[3];

  dsb_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .addr_s(addr_s),
    .row_act(row_act), .col_any_act(colu_act | coll_act),
    .col_fall(col_fall), .row_q(row_q), .col_q(col_q)
  );

  dsb_sequencer u_seq (
    .clk(clk), .rst_n(rst_n),
    .row_act(row_act), .colu_act(colu_act), .coll_act(coll_act),
    .wr_act(wr_act), .col_fall(col_fall),
    .ce_q(ce_q), .ub_q(ub_q), .lb_q(lb_q), .wr_q(wr_q)
  );

  assign sram_addr     = {row_q, col_q};
  assign sram_ce_n     = ~ce_q;
  assign sram_ub_n     = ~ub_q;
  assign sram_lb_n     = ~lb_q;
  assign sram_we_n     = ~(ce_q & wr_q);
  assign sram_data_out = host_data_in;
  assign sram_data_oe  = ce_q & wr_q;
  assign host_data_out = sram_data_in;
  assign host_data_oe  = ce_q & ~wr_q;
endmodule

// File: rtl/dsb_checker.sv
module dsb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        row_strb_n,
  input logic        colu_strb_n,
  input logic        coll_strb_n,
  input logic [17:0] sram_addr,
  input logic        sram_ce_n,
  input logic        sram_we_n,
  input logic        sram_ub_n,
  input logic        sram_lb_n,
  input logic        host_data_oe,
  input logic        sram_data_oe
);
  AST_CE_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> !$past(row_strb_n, 3)); // R6

  AST_ROW_HIGH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(row_strb_n, 3) |-> sram_ce_n); // R9

  AST_COLS_HIGH_END: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(colu_strb_n, 3) && $past(coll_strb_n, 3)) |-> sram_ce_n); // R9

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_data_oe && sram_data_oe)); // R7

  AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sram_data_oe |-> (!sram_we_n && !sram_ce_n)); // R8

  AST_LANE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ub_n || !sram_lb_n) |-> !sram_ce_n); // R5

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr)); // R3
endmodule

bind dram_sram_bridge dsb_checker u_dsb_checker (.*);

// File: tb/dram_sram_bridge_tb_top.sv
`timescale 1ns/1ps
module dram_sram_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  mux_addr = '0;
  logic        row_strb_n = 1'b1, colu_strb_n = 1'b1, coll_strb_n = 1'b1, wr_en_n = 1'b1;
  logic [15:0] host_data_in = '0, sram_data_in = '0;
  logic [15:0] host_data_out, sram_data_out;
  logic        host_data_oe, sram_data_oe;
  logic [17:0] sram_addr;
  logic        sram_ce_n, sram_we_n, sram_ub_n, sram_lb_n;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dram_sram_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .mux_addr(mux_addr),
    .row_strb_n(row_strb_n), .colu_strb_n(colu_strb_n), .coll_strb_n(coll_strb_n),
    .wr_en_n(wr_en_n), .host_data_in(host_data_in), .host_data_out(host_data_out),
    .host_data_oe(host_data_oe), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
    .sram_we_n(sram_we_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n),
    .sram_data_in(sram_data_in), .sram_data_out(sram_data_out), .sram_data_oe(sram_data_oe)
  );

  typedef struct packed {
    logic        row_n, cu_n, cl_n, we_n;
    logic [8:0]  addr;
    logic [15:0] hd, sd;
    logic        ce_n, swe_n, ub_n, lb_n;
    logic [17:0] sa;
    logic        hoe, soe;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1,1,1,1, 9'h000, 16'h0000, 16'h0000, 1,1,1,1, {9'h000,9'h000}, 0,0}, // R1 idle
    '{0,1,1,1, 9'h155, 16'h0000, 16'h0000, 1,1,1,1, {9'h155,9'h000}, 0,0}, // R2 row capture
    '{0,0,0,1, 9'h0AA, 16'h0000, 16'h1234, 0,1,0,0, {9'h155,9'h0AA}, 1,0}, // R3 R4 R5 R7 word read
    '{1,1,1,1, 9'h0AA, 16'h0000, 16'h1234, 1,1,1,1, {9'h155,9'h0AA}, 0,0}, // R9 end
    '{0,1,1,1, 9'h1F0, 16'h0000, 16'h0000, 1,1,1,1, {9'h1F0,9'h0AA}, 0,0}, // R2 new row
    '{0,0,1,0, 9'h00F, 16'hABCD, 16'h0000, 0,0,0,1, {9'h1F0,9'h00F}, 0,1}, // R5 R8 upper write
    '{0,1,1,0, 9'h00F, 16'hABCD, 16'h0000, 1,1,1,1, {9'h1F0,9'h00F}, 0,0}, // R9 cols high
    '{0,1,0,1, 9'h033, 16'h0000, 16'h5A5A, 0,1,1,0, {9'h1F0,9'h033}, 1,0}, // R10 R5 lower read
    '{1,1,0,1, 9'h033, 16'h0000, 16'h5A5A, 1,1,1,1, {9'h1F0,9'h033}, 0,0}, // R9 row high
    '{1,1,1,1, 9'h033, 16'h0000, 16'h0000, 1,1,1,1, {9'h1F0,9'h033}, 0,0}, // R9 idle
    '{1,0,0,1, 9'h111, 16'h0000, 16'h0000, 1,1,1,1, {9'h1F0,9'h111}, 0,0}, // R6 R3 refresh order
    '{0,0,0,1, 9'h0C3, 16'h0000, 16'h0000, 1,1,1,1, {9'h0C3,9'h111}, 0,0}, // R6 row after cols
    '{1,1,1,1, 9'h0C3, 16'h0000, 16'h0000, 1,1,1,1, {9'h0C3,9'h111}, 0,0}  // R9 idle
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, "ce_n", {31'd0, sram_ce_n}, 32'd1);
    chk(req, "we_n", {31'd0, sram_we_n}, 32'd1);
    chk(req, "ub_lb", {30'd0, sram_ub_n, sram_lb_n}, 32'd3);
    chk(req, "oes", {30'd0, host_data_oe, sram_data_oe}, 32'd0);
  endtask

  initial begin : watchdog
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk_idle("R1");                                       // R1 during reset
    chk("R1", "addr", {14'd0, sram_addr}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      row_strb_n = VEC[i].row_n; colu_strb_n = VEC[i].cu_n; coll_strb_n = VEC[i].cl_n;
      wr_en_n = VEC[i].we_n; mux_addr = VEC[i].addr;
      host_data_in = VEC[i].hd; sram_data_in = VEC[i].sd;
      repeat (5) @(negedge clk);
      chk($sformatf("vec%0d", i), "ce_n", {31'd0, sram_ce_n}, {31'd0, VEC[i].ce_n});
      chk($sformatf("vec%0d", i), "we_n", {31'd0, sram_we_n}, {31'd0, VEC[i].swe_n});
      chk($sformatf("vec%0d", i), "ub_lb", {30'd0, sram_ub_n, sram_lb_n}, {30'd0, VEC[i].ub_n, VEC[i].lb_n});
      chk($sformatf("vec%0d", i), "addr", {14'd0, sram_addr}, {14'd0, VEC[i].sa});
      chk($sformatf("vec%0d", i), "oes", {30'd0, host_data_oe, sram_data_oe}, {30'd0, VEC[i].hoe, VEC[i].soe});
      if (VEC[i].hoe) chk("R7", "host_out", {16'd0, host_data_out}, {16'd0, VEC[i].sd});
      if (VEC[i].soe) chk("R8", "sram_out", {16'd0, sram_data_out}, {16'd0, VEC[i].hd});
    end

    // R4: exact latency of chip enable from a column fall with row low
    @(negedge clk); row_strb_n = 1'b0; mux_addr = 9'h0A5;
    repeat (5) @(negedge clk);
    colu_strb_n = 1'b0; coll_strb_n = 1'b0; mux_addr = 9'h15A;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R4", "ce_n after 2 edges", {31'd0, sram_ce_n}, 32'd1);
    @(posedge clk); @(negedge clk);
    chk("R4", "ce_n after 3 edges", {31'd0, sram_ce_n}, 32'd0);
    chk("R3", "addr with ce", {14'd0, sram_addr}, {14'd0, 9'h0A5, 9'h15A});

    // R1: reset in the middle of an access
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_idle("R1");
    chk("R1", "addr after reset", {14'd0, sram_addr}, 32'd0);
    row_strb_n = 1'b1; colu_strb_n = 1'b1; coll_strb_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_idle("R1");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule